// File: doc/BRIEF.md
# Virtual Interrupt List-Register Interface

This block is the guest-facing half of a virtualized interrupt controller for a single virtual CPU. A hypervisor loads a small set of list registers through a dedicated write port. Each register describes one virtual interrupt: its ID, the ID of the CPU that sent it, a priority, a two-bit state, an end-of-interrupt notify flag and a hardware-link flag. The guest sees a small register bus. Through it the guest can enable the interface, set a priority mask, acknowledge the best pending interrupt and signal end of interrupt.

The block raises a level request, `virq_out`, toward the CPU whenever the interface is enabled and some entry is eligible for delivery. When an end-of-interrupt leaves an entry empty and that entry asked to be notified, the block sets a per-entry bit in a 64-bit EOI status vector. In the same cycle it emits a one-cycle pulse for that bit, so the hypervisor can reclaim the slot.

Top module: `vlr_iface`

## Requirements
- R1: After reset, `virq_out` is 0, `eisr` is all zero, the control enable reads 0, the priority mask reads 0 and no bus response is pending.
- R2: A hypervisor write (`hv_we`) replaces every field of list register `hv_idx` and clears that register's bit in `eisr`.
- R3: Offset 0x00 is the control register, with the enable at bit 0; it can be read and written. Offset 0x04 holds the 5-bit priority mask in bits [4:0]; a write replaces it and a read returns it.
- R4: An entry is eligible only when its state is pending (code 01) and its priority is strictly below the mask. Among eligible entries the lowest priority value wins, and on a tie the lowest index wins.
- R5: A read of offset 0x0C (acknowledge) returns the winner's CPU ID in bits [12:10] and its virtual ID in bits [9:0]. It also moves that entry to active (code 10).
- R6: When no entry is eligible, an acknowledge returns 1023 with no error and changes no state.
- R7: When the winning entry has its hardware-link flag set, an acknowledge returns an error response with data 1023 and leaves the entry pending.
- R8: A write of offset 0x10 (end of interrupt) carries an ID in bits [9:0] and a CPU ID in bits [12:10]. It clears the active bit of the lowest-index entry whose state has the active bit set and whose IDs match. Active (10) becomes invalid (00), and pending-and-active (11) becomes pending (01). A write that matches nothing is ignored.
- R9: When an end-of-interrupt turns an entry invalid and that entry has its notify flag set, `eisr` bit [index] becomes 1. `eisr_pulse` bit [index] is high for exactly that one cycle. Bits of `eisr` at or above the number of list registers stay 0.
- R10: `virq_out` equals the control enable ANDed with "some entry is eligible", computed from registered state without delay.
- R11: Every bus request gets `bus_ack` on the next cycle. An unmapped offset, a write to 0x0C or a read of 0x10 gets `bus_err` with data 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Guest bus request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Error response |
| bus_rdata | output | 32 | Read data |
| hv_we | input | 1 | Hypervisor list-register load strobe |
| hv_idx | input | 2 | List register to load |
| hv_vid | input | 10 | Virtual interrupt ID |
| hv_cpu | input | 3 | Source CPU ID |
| hv_pri | input | 5 | Priority, lower value is more urgent |
| hv_state | input | 2 | State: 00 invalid, 01 pending, 10 active, 11 pending and active |
| hv_notify | input | 1 | Notify on end of interrupt |
| hv_hw | input | 1 | Hardware-link flag (unsupported) |
| virq_out | output | 1 | Virtual interrupt request to the CPU |
| eisr | output | 64 | EOI status, one bit per list register |
| eisr_pulse | output | 4 | One-cycle pulse when an `eisr` bit is set |

## Verification
The hardest situation to reach is the pending-and-active entry. The guest can never create one, so the stimulus loads it directly through the hypervisor port. An end-of-interrupt then has to turn it back into a deliverable pending entry without any EOI status bit being raised. A second case needs the same path: an entry is made notifiable and then acknowledged, a mismatched end-of-interrupt is sent first and the matching one second. This shows through `eisr` that the mismatch left the active entry untouched. The hardware-link case is reached by reloading a slot with the flag set, at a priority that makes it the winner.

// File: rtl/vlr_pkg.sv
// Package: shared widths, state codes and bus offsets for the virtual
// interrupt list-register interface. Assumes the ID layout of the
// acknowledge and EOI data words is fixed (ID in [9:0], CPU in [12:10]).
package vlr_pkg;
    localparam int ID_W   = 10;
    localparam int CPU_W  = 3;
    localparam int PRI_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int EISR_W = 64;

    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        LR_INVALID  = 2'b00,
        LR_PENDING  = 2'b01,
        LR_ACTIVE   = 2'b10,
        LR_PEND_ACT = 2'b11
    } lr_state_e;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PMASK = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ACK   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_EOI   = 8'h10;
endpackage

// File: rtl/vlr_decode.sv
// Bus decoder: turns one guest bus request into at most one operation
// strobe, or an error flag for unmapped offsets and wrong directions.
// Assumes bus_req is high for exactly one cycle per access.
module vlr_decode
    import vlr_pkg::*;
(
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_ctrl,
    output logic              wr_pmask,
    output logic              rd_ctrl,
    output logic              rd_pmask,
    output logic              do_ack,
    output logic              do_eoi,
    output logic              bad
);
    // Decode the offset and direction into operation strobes.
    always_comb begin
        wr_ctrl  = req &&  wr && (addr == OFF_CTRL);
        rd_ctrl  = req && !wr && (addr == OFF_CTRL);
        wr_pmask = req &&  wr && (addr == OFF_PMASK);
        rd_pmask = req && !wr && (addr == OFF_PMASK);
        do_ack   = req && !wr && (addr == OFF_ACK);
        do_eoi   = req &&  wr && (addr == OFF_EOI);
        bad      = req && !(wr_ctrl || rd_ctrl || wr_pmask || rd_pmask ||
                            do_ack || do_eoi);
    end
endmodule

// File: rtl/vlr_select.sv
// Arbiter: finds the best eligible pending list register. Eligible means
// state pending and priority strictly below the mask; the lowest priority
// value wins and ties go to the lowest index. Purely combinational.
module vlr_select
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_LR-1:0][1:0]       state,
    input  logic [NUM_LR-1:0][PRI_W-1:0] pri,
    input  logic [PRI_W-1:0]             pmask,
    output logic                         any_elig,
    output logic [IDX_W-1:0]             sel_idx
);
    logic [PRI_W-1:0] best_pri;

    // Linear scan, strict compare keeps the lowest index on ties.
    always_comb begin
        any_elig = 1'b0;
        best_pri = '0;
        sel_idx  = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (state[i] == LR_PENDING && pri[i] < pmask) begin
                if (!any_elig || pri[i] < best_pri) begin
                    any_elig = 1'b1;
                    best_pri = pri[i];
                    sel_idx  = IDX_W'(i);
                end
            end
        end
    end
endmodule

// File: rtl/vlr_eoi_match.sv
// EOI matcher: finds the lowest-index list register whose active bit is
// set and whose virtual ID and CPU ID equal the EOI word. Combinational.
module vlr_eoi_match
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_LR-1:0][1:0]       state,
    input  logic [NUM_LR-1:0][ID_W-1:0]  vid,
    input  logic [NUM_LR-1:0][CPU_W-1:0] cpu,
    input  logic [ID_W-1:0]              q_vid,
    input  logic [CPU_W-1:0]             q_cpu,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    // First matching active entry in index order.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (!hit && state[i][1] && vid[i] == q_vid && cpu[i] == q_cpu) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vlr_iface.sv
// Top: virtual interrupt list-register interface for one virtual CPU.
// Holds NUM_LR list registers loaded by the hypervisor port, serves the
// guest bus (control, priority mask, acknowledge, end of interrupt) with a
// one-cycle registered response, drives virq_out and the EOI status bits.
// Assumes one bus access per request cycle and NUM_LR below 64.
module vlr_iface
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              hv_we,
    input  logic [IDX_W-1:0]  hv_idx,
    input  logic [ID_W-1:0]   hv_vid,
    input  logic [CPU_W-1:0]  hv_cpu,
    input  logic [PRI_W-1:0]  hv_pri,
    input  logic [1:0]        hv_state,
    input  logic              hv_notify,
    input  logic              hv_hw,
    output logic              virq_out,
    output logic [EISR_W-1:0] eisr,
    output logic [NUM_LR-1:0] eisr_pulse
);
    // List register storage
    logic [NUM_LR-1:0][ID_W-1:0]  lr_vid;
    logic [NUM_LR-1:0][CPU_W-1:0] lr_cpu;
    logic [NUM_LR-1:0][PRI_W-1:0] lr_pri;
    logic [NUM_LR-1:0][1:0]       lr_state;
    logic [NUM_LR-1:0]            lr_notify;
    logic [NUM_LR-1:0]            lr_hw;
    logic [NUM_LR-1:0]            eisr_q;
    logic [NUM_LR-1:0]            eisr_set;
    logic [NUM_LR-1:0]            pulse_q;

    logic             ctrl_en;
    logic [PRI_W-1:0] pmask;

    logic             wr_ctrl, wr_pmask, rd_ctrl, rd_pmask, do_ack, do_eoi, bad;
    logic             any_elig;
    logic [IDX_W-1:0] sel_idx;
    logic             eoi_hit;
    logic [IDX_W-1:0] eoi_idx;
    logic             ack_fire, ack_hw, eoi_fire;

    logic              rsp_ack, rsp_err;
    logic [DATA_W-1:0] rsp_data;

    logic unused_wdata_hi;
    assign unused_wdata_hi = &{1'b0, bus_wdata[DATA_W-1:ID_W+CPU_W]};

    vlr_decode u_decode (
        .req      (bus_req),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wr_ctrl  (wr_ctrl),
        .wr_pmask (wr_pmask),
        .rd_ctrl  (rd_ctrl),
        .rd_pmask (rd_pmask),
        .do_ack   (do_ack),
        .do_eoi   (do_eoi),
        .bad      (bad)
    );

    vlr_select #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_select (
        .state    (lr_state),
        .pri      (lr_pri),
        .pmask    (pmask),
        .any_elig (any_elig),
        .sel_idx  (sel_idx)
    );

    vlr_eoi_match #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_match (
        .state   (lr_state),
        .vid     (lr_vid),
        .cpu     (lr_cpu),
        .q_vid   (bus_wdata[ID_W-1:0]),
        .q_cpu   (bus_wdata[ID_W+CPU_W-1:ID_W]),
        .hit     (eoi_hit),
        .hit_idx (eoi_idx)
    );

    // Qualify acknowledge and EOI with the arbiter and matcher results.
    always_comb begin
        ack_fire = do_ack && any_elig && !lr_hw[sel_idx];
        ack_hw   = do_ack && any_elig &&  lr_hw[sel_idx];
        eoi_fire = do_eoi && eoi_hit;
    end

    // Per-entry EOI status set condition: entry goes invalid with notify.
    always_comb begin
        for (int i = 0; i < NUM_LR; i++) begin
            eisr_set[i] = eoi_fire && (eoi_idx == IDX_W'(i)) &&
                          !lr_state[i][0] && lr_notify[i] &&
                          !(hv_we && hv_idx == IDX_W'(i));
        end
    end

    // Interface control and priority mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            pmask   <= '0;
        end else begin
            if (wr_ctrl)  ctrl_en <= bus_wdata[0];
            if (wr_pmask) pmask   <= bus_wdata[PRI_W-1:0];
        end
    end

    // List registers: hypervisor load wins, else acknowledge / EOI updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_vid    <= '0;
            lr_cpu    <= '0;
            lr_pri    <= '0;
            lr_state  <= '0;
            lr_notify <= '0;
            lr_hw     <= '0;
            eisr_q    <= '0;
            pulse_q   <= '0;
        end else begin
            pulse_q <= eisr_set;
            for (int i = 0; i < NUM_LR; i++) begin
                if (hv_we && hv_idx == IDX_W'(i)) begin
                    lr_vid[i]    <= hv_vid;
                    lr_cpu[i]    <= hv_cpu;
                    lr_pri[i]    <= hv_pri;
                    lr_state[i]  <= hv_state;
                    lr_notify[i] <= hv_notify;
                    lr_hw[i]     <= hv_hw;
                    eisr_q[i]    <= 1'b0;
                end else begin
                    if (ack_fire && sel_idx == IDX_W'(i))
                        lr_state[i] <= LR_ACTIVE;
                    if (eoi_fire && eoi_idx == IDX_W'(i))
                        lr_state[i] <= {1'b0, lr_state[i][0]};
                    if (eisr_set[i])
                        eisr_q[i] <= 1'b1;
                end
            end
        end
    end

    // Registered bus response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack  <= 1'b0;
            rsp_err  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_ack <= bus_req;
            rsp_err <= bad || ack_hw;
            if (rd_ctrl)
                rsp_data <= DATA_W'(ctrl_en);
            else if (rd_pmask)
                rsp_data <= DATA_W'(pmask);
            else if (do_ack)
                rsp_data <= ack_fire ? DATA_W'({lr_cpu[sel_idx], lr_vid[sel_idx]})
                                     : DATA_W'(SPURIOUS_ID);
            else
                rsp_data <= '0;
        end
    end

    assign bus_ack    = rsp_ack;
    assign bus_err    = rsp_err;
    assign bus_rdata  = rsp_data;
    assign virq_out   = ctrl_en && any_elig;
    assign eisr       = {{(EISR_W-NUM_LR){1'b0}}, eisr_q};
    assign eisr_pulse = pulse_q;

    // Assertions guarding the logic above.
    p_one_cycle_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);
    p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);
    p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ack && !any_elig) |=> (bus_rdata == DATA_W'(SPURIOUS_ID) && !bus_err));
    p_ack_activates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !hv_we) |=> (lr_state[$past(sel_idx)] == LR_ACTIVE));
    p_hw_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hw && !hv_we) |=> (bus_err && lr_state[$past(sel_idx)] == LR_PENDING));
    p_virq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        virq_out |-> (ctrl_en && pmask != '0));
    p_pulse_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eisr_pulse));

    for (genvar g = 0; g < NUM_LR; g++) begin : g_eisr_chk
        p_eisr_invalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(eisr_q[g]) |-> (lr_state[g] == LR_INVALID && eisr_pulse[g]));
    end
endmodule

// File: tb/vlr_iface_bench.sv
// Scoreboard bench: bus_op pushes the expected response, a monitor pops
// and compares on each bus_ack; direct checks cover virq_out and eisr.
module vlr_iface_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        hv_we = 1'b0;
    logic [1:0]  hv_idx = '0;
    logic [9:0]  hv_vid = '0;
    logic [2:0]  hv_cpu = '0;
    logic [4:0]  hv_pri = '0;
    logic [1:0]  hv_state = '0;
    logic        hv_notify = 1'b0, hv_hw = 1'b0;
    logic        virq_out;
    logic [63:0] eisr;
    logic [3:0]  eisr_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] exp_d_q[$];
    logic        exp_e_q[$];
    string       exp_t_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vlr_iface u_vlr_iface (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata),
        .hv_we(hv_we), .hv_idx(hv_idx), .hv_vid(hv_vid), .hv_cpu(hv_cpu),
        .hv_pri(hv_pri), .hv_state(hv_state), .hv_notify(hv_notify),
        .hv_hw(hv_hw), .virq_out(virq_out), .eisr(eisr),
        .eisr_pulse(eisr_pulse)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            if (exp_d_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R11 unexpected response actual=%0h expected=none", bus_rdata);
            end else begin
                automatic logic [31:0] ed = exp_d_q.pop_front();
                automatic logic        ee = exp_e_q.pop_front();
                automatic string       et = exp_t_q.pop_front();
                check({et, " data"}, 64'(bus_rdata), 64'(ed));
                check({et, " err"}, 64'(bus_err), 64'(ee));
            end
        end
    end

    // Driver: one bus access, expected response pushed to the scoreboard.
    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                          input logic [31:0] ed, input logic ee, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        exp_d_q.push_back(ed); exp_e_q.push_back(ee); exp_t_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic hv_load(input int idx, input int vid, input int cpu, input int pri,
                           input int st, input logic nt, input logic hw);
        @(negedge clk);
        hv_we = 1'b1; hv_idx = 2'(idx); hv_vid = 10'(vid); hv_cpu = 3'(cpu);
        hv_pri = 5'(pri); hv_state = 2'(st); hv_notify = nt; hv_hw = hw;
        @(negedge clk);
        hv_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 virq reset", 64'(virq_out), 0);
        check("R1 eisr reset", eisr, 0);
        check("R1 no response", 64'(bus_ack), 0);
        bus_op(0, 8'h00, 0, 0, 0, "R1 ctrl reset");
        bus_op(0, 8'h04, 0, 0, 0, "R1 pmask reset");

        // R2 loads; mask 0 leaves nothing eligible
        hv_load(0, 5, 1, 8, 1, 0, 0);
        hv_load(1, 7, 2, 4, 1, 0, 0);
        hv_load(2, 9, 0, 4, 1, 0, 0);
        bus_op(0, 8'h0C, 0, 1023, 0, "R6 spurious with mask 0");

        bus_op(1, 8'h00, 1, 0, 0, "R3 ctrl write");
        bus_op(1, 8'h04, 16, 0, 0, "R3 pmask write");
        check("R10 virq enabled", 64'(virq_out), 1);
        bus_op(0, 8'h04, 0, 16, 0, "R3 pmask read");
        bus_op(0, 8'h0C, 0, (2 << 10) | 7, 0, "R4 tie lowest index R5");
        bus_op(0, 8'h0C, 0, 9, 0, "R4 second of tie");
        bus_op(1, 8'h04, 8, 0, 0, "R3 pmask 8");
        check("R4 strict mask virq", 64'(virq_out), 0);
        bus_op(0, 8'h0C, 0, 1023, 0, "R6 masked spurious");
        bus_op(1, 8'h04, 9, 0, 0, "R3 pmask 9");
        check("R4 mask opens virq", 64'(virq_out), 1);
        bus_op(0, 8'h0C, 0, (1 << 10) | 5, 0, "R5 ack LR0");
        check("R10 nothing pending", 64'(virq_out), 0);
        bus_op(0, 8'h0C, 0, 1023, 0, "R6 all active");

        // R10 enable gating
        bus_op(1, 8'h00, 0, 0, 0, "R3 disable");
        hv_load(3, 3, 7, 1, 1, 1, 0);
        check("R10 disabled virq", 64'(virq_out), 0);
        bus_op(1, 8'h00, 1, 0, 0, "R3 enable");
        check("R10 enabled virq", 64'(virq_out), 1);
        bus_op(0, 8'h0C, 0, (7 << 10) | 3, 0, "R5 ack LR3");

        // R8 mismatch ignored, then R9 match with notify
        bus_op(1, 8'h10, (6 << 10) | 3, 0, 0, "R8 eoi mismatch");
        check("R8 mismatch eisr", eisr, 0);
        bus_op(1, 8'h10, (7 << 10) | 3, 0, 0, "R9 eoi match");
        check("R9 eisr bit3", eisr, 64'h8);
        check("R9 pulse bit3", 64'(eisr_pulse), 64'h8);
        @(negedge clk);
        check("R9 pulse one cycle", 64'(eisr_pulse), 0);
        bus_op(1, 8'h10, (2 << 10) | 7, 0, 0, "R8 eoi no notify");
        check("R9 no notify eisr", eisr, 64'h8);

        // R8 pending-and-active
        hv_load(0, 20, 0, 2, 3, 1, 0);
        check("R4 pend-act not eligible", 64'(virq_out), 0);
        bus_op(1, 8'h10, 20, 0, 0, "R8 eoi pend-act");
        check("R8 pend-act to pending eisr", eisr, 64'h8);
        check("R8 pend-act now eligible", 64'(virq_out), 1);
        bus_op(0, 8'h0C, 0, 20, 0, "R5 ack LR0 again");
        bus_op(1, 8'h10, 20, 0, 0, "R9 eoi LR0");
        check("R9 eisr bits 0 and 3", eisr, 64'h9);

        // R2 reload clears eisr bit; R7 hardware link
        hv_load(3, 4, 0, 1, 1, 0, 1);
        check("R2 reload clears eisr", eisr, 64'h1);
        bus_op(0, 8'h0C, 0, 1023, 1, "R7 hw link error");
        check("R7 entry still pending", 64'(virq_out), 1);
        hv_load(3, 4, 0, 1, 1, 0, 0);
        bus_op(0, 8'h0C, 0, 4, 0, "R7 after clearing hw");

        // R11 unmapped and wrong direction
        bus_op(0, 8'h08, 0, 0, 1, "R11 unmapped read");
        bus_op(1, 8'h0C, 0, 0, 1, "R11 write to ack");
        bus_op(0, 8'h10, 0, 0, 1, "R11 read of eoi");
        bus_op(1, 8'h20, 0, 0, 1, "R11 unmapped write");
        bus_op(0, 8'h00, 0, 1, 0, "R11 ctrl unchanged");
        @(negedge clk);
        check("R11 scoreboard drained", 64'(exp_d_q.size()), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule